// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block carries out one atomic memory operation at a time. A request supplies an operation code, a byte address, an access width, a source operand, and the acquire and release ordering flags. The unit then reads the old memory value and combines it with the operand. It writes the new value back and hands the old value to the destination register. The bus is locked from the read through the write, so no other agent can slip in between them.

The sequencer has five named states. The transitions are:

- **IDLE → READ**: a legal, aligned, translated request is accepted.
- **IDLE → DONE**: an accepted request is illegal, misaligned or faulted in translation.
- **READ → COMPUTE**: the read returns without error.
- **READ → DONE**: the read returns an error.
- **COMPUTE → WRITE**: the new value has been computed.
- **WRITE → DONE**: the write has been issued.
- **DONE → IDLE**: always, after one cycle.

In DONE the unit pulses `done` for one cycle. In that cycle it either raises the writeback strobe or reports an exception code.

One datapath handles signed and unsigned min/max. The operation decides how the operand and the loaded value are extended from the access width. The old value returned to the register file is always sign-extended.

Top module: `amo_rmw_unit`

## Requirements
- R1: Operation codes `req_op` are 00001 swap, 00000 add, 00100 xor, 01100 and, 01000 or. Swap stores the operand. The others store operand OP loaded value.
- R2: Codes 10000 min and 10100 max compare as signed integers. Codes 11000 minu and 11100 maxu compare as unsigned integers.
- R3: `req_width` is 0 byte, 1 half, 2 word, 3 double. For minu and maxu, both the operand and the loaded value are zero-extended from that width. For every other operation, both are sign-extended.
- R4: `rd_data` is the loaded value sign-extended from the access width, whatever the operation.
- R5: `mem_size` equals the width code. `mem_wdata` carries the result in its low 2^width bytes, and all bits above them are zero.
- R6: During the read, `mem_acq` = aq and `mem_rel` = aq AND rl. During the write, `mem_acq` = aq AND rl and `mem_rel` = rl. Outside these two cycles both are 0.
- R7: `req_ready` is high only in IDLE.
  - A request accepted at a clock edge is read in the next cycle, computed in the cycle after that, and written in the cycle after that.
  - `done` then pulses for exactly one cycle.
- R8: `bus_lock` is high from the read cycle through the write cycle, and low otherwise.
- R9: An address that is not aligned to the access width gives `exc_code` 2, with no memory access. `done` follows one cycle after acceptance.
- R10: A translation fault flagged with the request gives `exc_code` 3, with no memory access.
- R11: A read error gives `exc_code` 4 and suppresses the write. A write error gives `exc_code` 5. On any exception `rd_we` stays low.
- R12: An operation code outside R1/R2, or double width when XLEN is 32, gives `exc_code` 1, with no memory access. Illegal takes priority over misaligned, and misaligned over translation fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted this edge |
| req_op | input | 5 | Operation code |
| req_width | input | 2 | Access width code |
| req_addr | input | XLEN | Byte address |
| req_src | input | XLEN | Source operand |
| req_aq | input | 1 | Acquire flag |
| req_rl | input | 1 | Release flag |
| req_xlat_fault | input | 1 | Address translation failed |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | XLEN | Access address |
| mem_size | output | 2 | Access width code |
| mem_acq | output | 1 | Acquire ordering on this access |
| mem_rel | output | 1 | Release ordering on this access |
| mem_wdata | output | XLEN | Write data, low bytes valid |
| mem_rdata | input | XLEN | Read data, low bytes valid |
| mem_rd_err | input | 1 | Read error, valid in read cycle |
| mem_wr_err | input | 1 | Write error, valid in write cycle |
| bus_lock | output | 1 | Bus held for the atomic sequence |
| done | output | 1 | One-cycle completion pulse |
| rd_we | output | 1 | Destination writeback strobe |
| rd_data | output | XLEN | Old value for the destination |
| exc_valid | output | 1 | Exception reported with done |
| exc_code | output | 3 | Exception cause |

## Verification
Each operation runs at several widths against memory whose bytes above the access width hold a filler pattern. A wrong extension or a stray upper byte therefore shows up in both the stored value and the returned one.

Operands with the top bit of the access width set separate signed from unsigned min/max. The same values separate the zero-extended compare from the always-sign-extended return value.

The aq/rl combinations (1,1), (1,0) and (0,1) separate the ordering flags of the read from those of the write. Misaligned, untranslated, read-error, write-error and illegal-code requests each take a distinct exit from the sequence, and the bench follows every one cycle by cycle.

// File: rtl/amo_rmw_pkg.sv
package amo_rmw_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_COMPUTE,
        S_WRITE,
        S_DONE
    } amo_state_e;

    typedef enum logic [2:0] {
        X_NONE     = 3'd0,
        X_ILLEGAL  = 3'd1,
        X_MISALIGN = 3'd2,
        X_XLAT     = 3'd3,
        X_RDERR    = 3'd4,
        X_WRERR    = 3'd5
    } amo_exc_e;

    localparam logic [4:0] F_ADD  = 5'b00000;
    localparam logic [4:0] F_SWAP = 5'b00001;
    localparam logic [4:0] F_XOR  = 5'b00100;
    localparam logic [4:0] F_OR   = 5'b01000;
    localparam logic [4:0] F_AND  = 5'b01100;
    localparam logic [4:0] F_MIN  = 5'b10000;
    localparam logic [4:0] F_MAX  = 5'b10100;
    localparam logic [4:0] F_MINU = 5'b11000;
    localparam logic [4:0] F_MAXU = 5'b11100;

    localparam logic [1:0] W_BYTE = 2'd0;
    localparam logic [1:0] W_HALF = 2'd1;
    localparam logic [1:0] W_WORD = 2'd2;
    localparam logic [1:0] W_DBL  = 2'd3;

    function automatic logic op_known(input logic [4:0] f);
        case (f)
            F_ADD, F_SWAP, F_XOR, F_OR, F_AND,
            F_MIN, F_MAX, F_MINU, F_MAXU: op_known = 1'b1;
            default:                       op_known = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/amo_req_check.sv
module amo_req_check
    import amo_rmw_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [4:0] op,
    input  logic [1:0] width,
    input  logic [2:0] addr_lo,
    input  logic       xlat_fault,
    output logic       fault,
    output amo_exc_e   code
);
    localparam bit DWORD_OK = (XLEN == 64);

    logic dword_legal;
    logic legal;
    logic aligned;

    generate
        if (DWORD_OK) begin : g_dw64
            assign dword_legal = 1'b1;
        end else begin : g_dw32
            assign dword_legal = 1'b0;
        end
    endgenerate

    always_comb begin
        legal = op_known(op) && ((width != W_DBL) || dword_legal);
        unique case (width)
            W_BYTE:  aligned = 1'b1;
            W_HALF:  aligned = (addr_lo[0] == 1'b0);
            W_WORD:  aligned = (addr_lo[1:0] == 2'b00);
            default: aligned = (addr_lo == 3'b000);
        endcase
        if (!legal)          code = X_ILLEGAL;
        else if (!aligned)   code = X_MISALIGN;
        else if (xlat_fault) code = X_XLAT;
        else                 code = X_NONE;
        fault = (code != X_NONE);
    end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_rmw_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [4:0]      op,
    input  logic [1:0]      width,
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] loaded,
    output logic [XLEN-1:0] result,
    output logic [XLEN-1:0] old_ext
);
    localparam int PAD_B = XLEN - 8;
    localparam int PAD_H = XLEN - 16;
    localparam int PAD_W = XLEN - 32;

    function automatic logic [XLEN-1:0] widen(input logic [XLEN-1:0] v,
                                              input logic [1:0] w,
                                              input logic uns);
        logic [XLEN-1:0] r;
        unique case (w)
            W_BYTE:  r = {{PAD_B{v[7]  & ~uns}}, v[7:0]};
            W_HALF:  r = {{PAD_H{v[15] & ~uns}}, v[15:0]};
            W_WORD:  begin
                if (PAD_W > 0) r = {{PAD_W{v[31] & ~uns}}, v[31:0]};
                else           r = v;
            end
            default: r = v;
        endcase
        return r;
    endfunction

    function automatic logic [XLEN-1:0] low_mask(input logic [1:0] w);
        logic [XLEN-1:0] m;
        unique case (w)
            W_BYTE:  m = {{PAD_B{1'b0}}, 8'hFF};
            W_HALF:  m = {{PAD_H{1'b0}}, 16'hFFFF};
            W_WORD:  begin
                if (PAD_W > 0) m = {{PAD_W{1'b0}}, 32'hFFFF_FFFF};
                else           m = '1;
            end
            default: m = '1;
        endcase
        return m;
    endfunction

    logic            uns;
    logic [XLEN-1:0] a_v;
    logic [XLEN-1:0] b_v;
    logic            a_lt_s;
    logic            a_lt_u;
    logic [XLEN-1:0] full;

    always_comb begin
        uns    = (op == F_MINU) || (op == F_MAXU);
        a_v    = widen(src, width, uns);
        b_v    = widen(loaded, width, uns);
        a_lt_s = $signed(a_v) < $signed(b_v);
        a_lt_u = a_v < b_v;
        unique case (op)
            F_SWAP:  full = a_v;
            F_ADD:   full = a_v + b_v;
            F_XOR:   full = a_v ^ b_v;
            F_AND:   full = a_v & b_v;
            F_OR:    full = a_v | b_v;
            F_MIN:   full = a_lt_s ? a_v : b_v;
            F_MAX:   full = a_lt_s ? b_v : a_v;
            F_MINU:  full = a_lt_u ? a_v : b_v;
            F_MAXU:  full = a_lt_u ? b_v : a_v;
            default: full = a_v;
        endcase
        result  = full & low_mask(width);
        old_ext = widen(loaded, width, 1'b0);
    end
endmodule

// File: rtl/amo_rmw_seq.sv
module amo_rmw_seq
    import amo_rmw_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [4:0]      req_op,
    input  logic [1:0]      req_width,
    input  logic [XLEN-1:0] req_addr,
    input  logic [XLEN-1:0] req_src,
    input  logic            req_aq,
    input  logic            req_rl,
    input  logic            dec_fault,
    input  amo_exc_e        dec_code,
    input  logic [XLEN-1:0] alu_result,
    input  logic [XLEN-1:0] alu_old,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_rd_err,
    input  logic            mem_wr_err,
    output logic [4:0]      op_q,
    output logic [1:0]      width_q,
    output logic [XLEN-1:0] src_q,
    output logic [XLEN-1:0] loaded_q,
    output logic            req_ready,
    output logic            mem_rd_en,
    output logic            mem_wr_en,
    output logic [XLEN-1:0] mem_addr,
    output logic [1:0]      mem_size,
    output logic            mem_acq,
    output logic            mem_rel,
    output logic [XLEN-1:0] mem_wdata,
    output logic            bus_lock,
    output logic            done,
    output logic            rd_we,
    output logic [XLEN-1:0] rd_data,
    output logic            exc_valid,
    output logic [2:0]      exc_code
);
    amo_state_e      state, nxt;
    logic [XLEN-1:0] addr_q;
    logic [XLEN-1:0] result_q;
    logic [XLEN-1:0] old_q;
    logic            aq_q, rl_q;
    logic            exc_q;
    amo_exc_e        code_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (req_valid) nxt = dec_fault ? S_DONE : S_READ;
            S_READ:    nxt = mem_rd_err ? S_DONE : S_COMPUTE;
            S_COMPUTE: nxt = S_WRITE;
            S_WRITE:   nxt = S_DONE;
            S_DONE:    nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= '0;
            width_q  <= '0;
            addr_q   <= '0;
            src_q    <= '0;
            aq_q     <= 1'b0;
            rl_q     <= 1'b0;
            loaded_q <= '0;
            result_q <= '0;
            old_q    <= '0;
            exc_q    <= 1'b0;
            code_q   <= X_NONE;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    op_q    <= req_op;
                    width_q <= req_width;
                    addr_q  <= req_addr;
                    src_q   <= req_src;
                    aq_q    <= req_aq;
                    rl_q    <= req_rl;
                    exc_q   <= dec_fault;
                    code_q  <= dec_code;
                end
                S_READ: begin
                    loaded_q <= mem_rdata;
                    if (mem_rd_err) begin
                        exc_q  <= 1'b1;
                        code_q <= X_RDERR;
                    end
                end
                S_COMPUTE: begin
                    result_q <= alu_result;
                    old_q    <= alu_old;
                end
                S_WRITE: if (mem_wr_err) begin
                    exc_q  <= 1'b1;
                    code_q <= X_WRERR;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        req_ready = (state == S_IDLE);
        mem_rd_en = (state == S_READ);
        mem_wr_en = (state == S_WRITE);
        bus_lock  = (state == S_READ) || (state == S_COMPUTE) || (state == S_WRITE);
        mem_addr  = (mem_rd_en || mem_wr_en) ? addr_q : '0;
        mem_size  = width_q;
        mem_acq   = mem_rd_en ? aq_q : (mem_wr_en ? (aq_q & rl_q) : 1'b0);
        mem_rel   = mem_rd_en ? (aq_q & rl_q) : (mem_wr_en ? rl_q : 1'b0);
        mem_wdata = mem_wr_en ? result_q : '0;
        done      = (state == S_DONE);
        exc_valid = done && exc_q;
        rd_we     = done && !exc_q;
        rd_data   = rd_we ? old_q : '0;
        exc_code  = exc_valid ? code_q : 3'd0;
    end

    // R8
    lock_covers_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || mem_wr_en) |-> bus_lock);

    // R8
    lock_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(bus_lock));

    // R7
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    no_wb_on_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> !rd_we);

    // R6
    read_release_needs_acquire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && mem_rel) |-> mem_acq);
endmodule

// File: rtl/amo_rmw_unit.sv
module amo_rmw_unit
    import amo_rmw_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [4:0]      req_op,
    input  logic [1:0]      req_width,
    input  logic [XLEN-1:0] req_addr,
    input  logic [XLEN-1:0] req_src,
    input  logic            req_aq,
    input  logic            req_rl,
    input  logic            req_xlat_fault,
    output logic            mem_rd_en,
    output logic            mem_wr_en,
    output logic [XLEN-1:0] mem_addr,
    output logic [1:0]      mem_size,
    output logic            mem_acq,
    output logic            mem_rel,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_rd_err,
    input  logic            mem_wr_err,
    output logic            bus_lock,
    output logic            done,
    output logic            rd_we,
    output logic [XLEN-1:0] rd_data,
    output logic            exc_valid,
    output logic [2:0]      exc_code
);
    logic            dec_fault;
    amo_exc_e        dec_code;
    logic [4:0]      op_q;
    logic [1:0]      width_q;
    logic [XLEN-1:0] src_q;
    logic [XLEN-1:0] loaded_q;
    logic [XLEN-1:0] alu_result;
    logic [XLEN-1:0] alu_old;

    amo_req_check #(.XLEN(XLEN)) u_check (
        .op         (req_op),
        .width      (req_width),
        .addr_lo    (req_addr[2:0]),
        .xlat_fault (req_xlat_fault),
        .fault      (dec_fault),
        .code       (dec_code)
    );

    amo_alu #(.XLEN(XLEN)) u_alu (
        .op      (op_q),
        .width   (width_q),
        .src     (src_q),
        .loaded  (loaded_q),
        .result  (alu_result),
        .old_ext (alu_old)
    );

    amo_rmw_seq #(.XLEN(XLEN)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_width  (req_width),
        .req_addr   (req_addr),
        .req_src    (req_src),
        .req_aq     (req_aq),
        .req_rl     (req_rl),
        .dec_fault  (dec_fault),
        .dec_code   (dec_code),
        .alu_result (alu_result),
        .alu_old    (alu_old),
        .mem_rdata  (mem_rdata),
        .mem_rd_err (mem_rd_err),
        .mem_wr_err (mem_wr_err),
        .op_q       (op_q),
        .width_q    (width_q),
        .src_q      (src_q),
        .loaded_q   (loaded_q),
        .req_ready  (req_ready),
        .mem_rd_en  (mem_rd_en),
        .mem_wr_en  (mem_wr_en),
        .mem_addr   (mem_addr),
        .mem_size   (mem_size),
        .mem_acq    (mem_acq),
        .mem_rel    (mem_rel),
        .mem_wdata  (mem_wdata),
        .bus_lock   (bus_lock),
        .done       (done),
        .rd_we      (rd_we),
        .rd_data    (rd_data),
        .exc_valid  (exc_valid),
        .exc_code   (exc_code)
    );

    // R9
    faulted_request_skips_memory_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && dec_fault) |=> (!mem_rd_en && done));
endmodule

// File: tb/tb_amo_rmw_unit.sv
module tb_amo_rmw_unit;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [4:0]      req_op = '0;
    logic [1:0]      req_width = '0;
    logic [XLEN-1:0] req_addr = '0;
    logic [XLEN-1:0] req_src = '0;
    logic            req_aq = 1'b0;
    logic            req_rl = 1'b0;
    logic            req_xlat_fault = 1'b0;
    logic            mem_rd_en, mem_wr_en;
    logic [XLEN-1:0] mem_addr;
    logic [1:0]      mem_size;
    logic            mem_acq, mem_rel;
    logic [XLEN-1:0] mem_wdata;
    logic [XLEN-1:0] mem_rdata = '0;
    logic            mem_rd_err = 1'b0;
    logic            mem_wr_err = 1'b0;
    logic            bus_lock, done, rd_we, exc_valid;
    logic [XLEN-1:0] rd_data;
    logic [2:0]      exc_code;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] mem [256];

    always #(CLK_PERIOD / 2) clk = ~clk;

    amo_rmw_unit #(.XLEN(XLEN)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_width(req_width), .req_addr(req_addr), .req_src(req_src),
        .req_aq(req_aq), .req_rl(req_rl), .req_xlat_fault(req_xlat_fault),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_acq(mem_acq), .mem_rel(mem_rel),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rd_err(mem_rd_err),
        .mem_wr_err(mem_wr_err), .bus_lock(bus_lock), .done(done), .rd_we(rd_we),
        .rd_data(rd_data), .exc_valid(exc_valid), .exc_code(exc_code)
    );

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [63:0] bext(input logic [63:0] v, input int w, input bit uns);
        int sh;
        logic [63:0] t;
        sh = 64 - 8 * (1 << w);
        t = v << sh;
        if (uns) return t >> sh;
        return $signed(t) >>> sh;
    endfunction

    function automatic bit is_legal(input logic [4:0] op);
        return op inside {5'b00000, 5'b00001, 5'b00100, 5'b01000, 5'b01100,
                          5'b10000, 5'b10100, 5'b11000, 5'b11100};
    endfunction

    task automatic run_amo(input string tag, input logic [4:0] op, input int w,
                           input logic [7:0] a, input logic [63:0] src,
                           input bit aq, input bit rl, input bit xf,
                           input bit rerr, input bit werr);
        int nb;
        int code;
        bit uns;
        logic [63:0] raw, x, y, res, mask, exp_wd, exp_old;
        int ph[$];
        nb = 1 << w;
        code = !is_legal(op) ? 1 : ((int'(a) % nb) != 0) ? 2 : xf ? 3 : rerr ? 4 : werr ? 5 : 0;
        raw = 64'hA5A5_A5A5_A5A5_A5A5;
        for (int i = 0; i < nb; i++) raw[8*i +: 8] = mem[8'(a + i)];
        uns = (op == 5'b11000) || (op == 5'b11100);
        x = bext(src, w, uns);
        y = bext(raw, w, uns);
        case (op)
            5'b00001: res = x;
            5'b00000: res = x + y;
            5'b00100: res = x ^ y;
            5'b01100: res = x & y;
            5'b01000: res = x | y;
            5'b10000: res = ($signed(x) < $signed(y)) ? x : y;
            5'b10100: res = ($signed(x) > $signed(y)) ? x : y;
            5'b11000: res = (x < y) ? x : y;
            default:  res = (x > y) ? x : y;
        endcase
        mask = (nb == 8) ? '1 : ((64'd1 << (8 * nb)) - 1);
        exp_wd = res & mask;
        exp_old = bext(raw, w, 1'b0);
        if (code inside {1, 2, 3}) ph = {4};
        else if (code == 4) ph = {1, 4};
        else ph = {1, 2, 3, 4};

        @(negedge clk);
        chk({tag, " R7 ready before accept"}, 64'(req_ready), 64'd1);
        req_op = op; req_width = 2'(w); req_addr = 64'(a); req_src = src;
        req_aq = aq; req_rl = rl; req_xlat_fault = xf; req_valid = 1'b1;
        foreach (ph[k]) begin
            @(negedge clk);
            req_valid = 1'b0;
            mem_rd_err = 1'b0;
            mem_wr_err = 1'b0;
            chk({tag, " R7 ready"}, 64'(req_ready), 64'd0);
            chk({tag, " R7 rd_en"}, 64'(mem_rd_en), 64'(ph[k] == 1));
            chk({tag, " R7 wr_en"}, 64'(mem_wr_en), 64'(ph[k] == 3));
            chk({tag, " R8 lock"}, 64'(bus_lock), 64'(ph[k] != 4));
            chk({tag, " R7 done"}, 64'(done), 64'(ph[k] == 4));
            if (ph[k] == 1) begin
                chk({tag, " R6 read acq"}, 64'(mem_acq), 64'(aq));
                chk({tag, " R6 read rel"}, 64'(mem_rel), 64'(aq & rl));
                chk({tag, " R5 size"}, 64'(mem_size), 64'(w));
                chk({tag, " read addr"}, mem_addr, 64'(a));
                mem_rdata = raw;
                mem_rd_err = rerr;
            end
            if (ph[k] == 2) begin
                chk({tag, " R6 idle acq"}, 64'(mem_acq), 64'd0);
            end
            if (ph[k] == 3) begin
                chk({tag, " R6 write acq"}, 64'(mem_acq), 64'(aq & rl));
                chk({tag, " R6 write rel"}, 64'(mem_rel), 64'(rl));
                chk({tag, " R5 wdata high bytes"}, mem_wdata & ~mask, 64'd0);
                chk({tag, " wdata"}, mem_wdata, exp_wd);
                chk({tag, " write addr"}, mem_addr, 64'(a));
                if (!werr)
                    for (int i = 0; i < nb; i++) mem[8'(a + i)] = mem_wdata[8*i +: 8];
                mem_wr_err = werr;
            end
            if (ph[k] == 4) begin
                chk({tag, " R11 rd_we"}, 64'(rd_we), 64'(code == 0));
                chk({tag, " exc_valid"}, 64'(exc_valid), 64'(code != 0));
                chk({tag, " exc_code"}, 64'(exc_code), 64'(code));
                if (code == 0) chk({tag, " R4 rd_data"}, rd_data, exp_old);
            end
        end
        @(negedge clk);
        mem_rd_err = 1'b0;
        mem_wr_err = 1'b0;
        chk({tag, " R7 back to idle"}, 64'(req_ready), 64'd1);
        chk({tag, " R8 lock released"}, 64'(bus_lock), 64'd0);
        chk({tag, " R7 done cleared"}, 64'(done), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
        mem[8'h40] = 8'h80; mem[8'h41] = 8'h00; mem[8'h42] = 8'h00; mem[8'h43] = 8'hF0;
        mem[8'h50] = 8'hF3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset R7 ready", 64'(req_ready), 64'd1);
        chk("reset R8 lock", 64'(bus_lock), 64'd0);
        chk("reset R7 done", 64'(done), 64'd0);
        chk("reset rd_en", 64'(mem_rd_en), 64'd0);

        run_amo("R1 swap word",   5'b00001, 2, 8'h10, 64'h1234_5678_9ABC_DEF0, 1, 1, 0, 0, 0);
        run_amo("R1 add dword",   5'b00000, 3, 8'h18, 64'hFFFF_0000_1111_2222, 1, 0, 0, 0, 0);
        run_amo("R1 xor half",    5'b00100, 1, 8'h22, 64'h0000_0000_0000_8001, 0, 1, 0, 0, 0);
        run_amo("R1 and byte",    5'b01100, 0, 8'h23, 64'h0000_0000_0000_00F0, 0, 0, 0, 0, 0);
        run_amo("R1 or word",     5'b01000, 2, 8'h24, 64'h8000_0000_0F0F_0F0F, 1, 1, 0, 0, 0);
        run_amo("R2 min word",    5'b10000, 2, 8'h40, 64'h0000_0000_0000_0005, 0, 0, 0, 0, 0);
        run_amo("R2 max word",    5'b10100, 2, 8'h40, 64'h0000_0000_0000_0005, 0, 0, 0, 0, 0);
        run_amo("R2 minu word",   5'b11000, 2, 8'h44, 64'h0000_0000_F000_0000, 0, 0, 0, 0, 0);
        run_amo("R3 maxu byte",   5'b11100, 0, 8'h50, 64'h0000_0000_0000_007F, 1, 0, 0, 0, 0);
        run_amo("R3 min half",    5'b10000, 1, 8'h60, 64'h0000_0000_0000_FFFE, 0, 1, 0, 0, 0);
        run_amo("R4 maxu dword",  5'b11100, 3, 8'h68, 64'h8000_0000_0000_0001, 1, 1, 0, 0, 0);
        run_amo("R9 misal half",  5'b00000, 1, 8'h31, 64'h1, 0, 0, 0, 0, 0);
        run_amo("R9 misal word",  5'b00001, 2, 8'h12, 64'h1, 0, 0, 0, 0, 0);
        run_amo("R9 misal dword", 5'b00001, 3, 8'h14, 64'h1, 0, 0, 1, 0, 0);
        run_amo("R10 xlat",       5'b00000, 2, 8'h70, 64'h1, 1, 1, 1, 0, 0);
        run_amo("R11 read err",   5'b00000, 2, 8'h74, 64'h1, 1, 0, 0, 1, 0);
        run_amo("R11 write err",  5'b01000, 2, 8'h78, 64'h1, 0, 1, 0, 0, 1);
        run_amo("R12 illegal op", 5'b00010, 2, 8'h13, 64'h1, 0, 0, 1, 0, 0);
        run_amo("R3 byte odd",    5'b00000, 0, 8'h7F, 64'h0000_0000_0000_0081, 0, 0, 0, 0, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule